// File: doc/BRIEF.md
# One-Shot Countdown Timer Bank

This block holds a parameterised set of independent down-counters that share one clock, nominally 20 MHz. A host writes a start count for each channel over a single-cycle synchronous write port: an address picks the channel, a data word carries the count, and a strobe commits it on a rising clock edge. Writes to every channel except the highest-numbered one only stage a value in that channel's holding register. A write to the highest-numbered channel stages its value and launches every channel in the same cycle.

Each channel drives one output. The output is high for exactly as many clocks as the staged count and then drops low. It stays low until a later launch. A staged count of zero leaves the output low. A launch while counters are still running reloads every channel from its staged value. The channel count defaults to 12 and the counter width to 14 bits.

Top module: `oneshot_timer_bank`

## Requirements
- R1: A write to channel k, where k is below NUM_CH-1, changes only k's staged count; no output changes in that cycle because of it, and a running count keeps its value.
- R2: No output goes high unless the highest channel (address NUM_CH-1) is written; writes to the other channels alone leave all outputs low.
- R3: A write to address NUM_CH-1 starts all channels on that clock edge. From the next cycle, output k is high for exactly its staged count N clocks, and low after that.
- R4: A channel whose staged count is zero keeps its output low when a launch occurs, including the launching channel written with zero.
- R5: After its count expires, an output stays low through any number of idle cycles and non-launching writes.
- R6: A launch while channels are running restarts every channel from its currently staged value, including values staged during the run.
- R7: A write to an address of NUM_CH or above stages nothing and starts nothing.
- R8: An active-high synchronous reset clears all counters and all staged counts, so all outputs are low in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, nominally 20 MHz |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_addr | input | ADDR_W | Channel number; NUM_CH-1 is the launching channel |
| wr_data | input | CNT_W | Count to stage for the addressed channel |
| busy_o | output | NUM_CH | One bit per channel, high while that channel counts |

## Verification
The hardest case to reach from the ports is a launch that lands while other channels are still mid-count, combined with a staged value that changed during that run. The stimulus table first runs a launch with mixed lengths. Before the shortest channel expires, it overwrites one staged count and then fires a second launch with a zero in the launching channel. The outputs must then show the old value still counting before the launch and the new value after it. Out-of-range addresses are written just before a launch, so any aliasing onto a real channel shows up as a wrong output bit.

// File: rtl/oneshot_timer_pkg.sv
package oneshot_timer_pkg;

   // Action a single write performs on the bank.
   typedef enum logic [1:0] {
      LD_NONE  = 2'd0,
      LD_STAGE = 2'd1,
      LD_LAUNCH = 2'd2
   } load_action_e;

   // Smallest address width able to name every channel.
   function automatic int chan_addr_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/oneshot_load_decode.sv
module oneshot_load_decode
   import oneshot_timer_pkg::*;
#(
   parameter int NUM_CH = 12,
   parameter int ADDR_W = chan_addr_w(NUM_CH)
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output logic [NUM_CH-1:0] stage_we,
   output logic              launch,
   output load_action_e      action
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_CH - 1);

   // Full-width compare per channel: addresses past the last channel match nothing.
   for (genvar k = 0; k < NUM_CH; k++) begin : g_sel
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(k);
      assign stage_we[k] = wr_en && (wr_addr == MY_ADDR);
   end

   assign launch = wr_en && (wr_addr == LAST_ADDR);

   always_comb begin
      if (launch)           action = LD_LAUNCH;
      else if (|stage_we)   action = LD_STAGE;
      else                  action = LD_NONE;
   end
endmodule

// File: rtl/oneshot_channel.sv
module oneshot_channel #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             stage_we,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             launch,
   output logic             busy
);
   logic [CNT_W-1:0] staged_q;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] launch_val;

   // The launching write's own data is used in the same cycle it is staged.
   assign launch_val = stage_we ? wr_data : staged_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         staged_q <= '0;
      end else if (stage_we) begin
         staged_q <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         count_q <= '0;
      end else if (launch) begin
         count_q <= launch_val;
      end else if (count_q != '0) begin
         count_q <= count_q - 1'b1;
      end
   end

   assign busy = (count_q != '0);
endmodule

// File: rtl/oneshot_timer_bank.sv
module oneshot_timer_bank
   import oneshot_timer_pkg::*;
#(
   parameter int NUM_CH = 12,
   parameter int CNT_W  = 14,
   parameter int ADDR_W = chan_addr_w(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [NUM_CH-1:0] busy_o
);
   // Elaboration-time parameter checks.
   if (NUM_CH < 2 || NUM_CH > 64) begin : g_bad_nch
      $error("oneshot_timer_bank: NUM_CH must lie in 2..64");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cw
      $error("oneshot_timer_bank: CNT_W must lie in 2..32");
   end
   if ((1 << ADDR_W) < NUM_CH) begin : g_bad_aw
      $error("oneshot_timer_bank: ADDR_W too narrow for NUM_CH");
   end

   logic [NUM_CH-1:0] stage_we;
   logic              launch;
   load_action_e      action;

   oneshot_load_decode #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W)
   ) u_decode (
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .stage_we (stage_we),
      .launch   (launch),
      .action   (action)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      oneshot_channel #(
         .CNT_W (CNT_W)
      ) u_ch (
         .clk      (clk),
         .rst      (rst),
         .stage_we (stage_we[k]),
         .wr_data  (wr_data),
         .launch   (launch),
         .busy     (busy_o[k])
      );
   end
endmodule

// File: rtl/oneshot_timer_bank_chk.sv
module oneshot_timer_bank_chk #(
   parameter int NUM_CH = 12,
   parameter int CNT_W  = 14,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [CNT_W-1:0]  wr_data,
   input logic [NUM_CH-1:0] busy_o
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_CH - 1);

   logic is_launch;
   assign is_launch = wr_en && (wr_addr == LAST_ADDR);

   // R8: reset leaves every output low on the following cycle.
   a_r8_reset_clears: assert property (@(posedge clk)
      rst |=> (busy_o == '0));

   // R2: an idle output can only rise after a launching write.
   for (genvar k = 0; k < NUM_CH; k++) begin : g_rise
      a_r2_rise_needs_launch: assert property (@(posedge clk) disable iff (rst)
         (!busy_o[k] && !is_launch) |=> !busy_o[k]);
   end

   // R3: a nonzero count written to the launching channel drives it high next cycle.
   a_r3_launch_raises: assert property (@(posedge clk) disable iff (rst)
      (is_launch && (wr_data != '0)) |=> busy_o[NUM_CH-1]);

   // R4: a zero written to the launching channel keeps it low.
   a_r4_zero_stays_low: assert property (@(posedge clk) disable iff (rst)
      (is_launch && (wr_data == '0)) |=> !busy_o[NUM_CH-1]);
endmodule

bind oneshot_timer_bank oneshot_timer_bank_chk #(
   .NUM_CH (NUM_CH),
   .CNT_W  (CNT_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .busy_o  (busy_o)
);

// File: tb/oneshot_timer_bank_test.sv
`timescale 1ns/1ps
module oneshot_timer_bank_test;
   localparam int NCH  = 5;
   localparam int CW   = 14;
   localparam int AW   = 3;
   localparam int ROWS = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic [NCH-1:0] busy;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   oneshot_timer_bank #(
      .NUM_CH (NCH),
      .CNT_W  (CW),
      .ADDR_W (AW)
   ) uut (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .busy_o  (busy)
   );

   // Row: {write strobe, address, data, expected busy[4:0] after the edge}.
   // Channel 4 is the launching channel.
   localparam logic [22:0] VEC [ROWS] = '{
      {1'b1, 3'd0, 14'd3, 5'b00000},  // R2 stage ch0
      {1'b1, 3'd1, 14'd1, 5'b00000},  // R2 stage ch1
      {1'b1, 3'd2, 14'd0, 5'b00000},  // R2 stage ch2 (zero)
      {1'b1, 3'd3, 14'd2, 5'b00000},  // R2 stage ch3
      {1'b1, 3'd4, 14'd4, 5'b11011},  // R3 launch, R4 ch2 zero
      {1'b0, 3'd0, 14'd0, 5'b11001},  // R3 ch1 expired after 1
      {1'b0, 3'd0, 14'd0, 5'b10001},  // R3 ch3 expired after 2
      {1'b0, 3'd0, 14'd0, 5'b10000},  // R3 ch0 expired after 3
      {1'b0, 3'd0, 14'd0, 5'b00000},  // R3 ch4 expired after 4
      {1'b0, 3'd0, 14'd0, 5'b00000},  // R5 stays low
      {1'b1, 3'd1, 14'd2, 5'b00000},  // R5 staging does not relaunch
      {1'b1, 3'd4, 14'd1, 5'b11011},  // R3 second launch
      {1'b1, 3'd0, 14'd6, 5'b01011},  // R1 mid-run stage of ch0
      {1'b1, 3'd4, 14'd0, 5'b01011},  // R6 restart, R4 last zero
      {1'b0, 3'd0, 14'd0, 5'b01011},  // R6 ch0 counts new value
      {1'b0, 3'd0, 14'd0, 5'b00001}   // R6 ch1/ch3 from held values
   };

   function automatic string row_tag(input int r);
      if (r < 4)        return "R2";
      else if (r < 9)   return "R3";
      else if (r < 11)  return "R5";
      else if (r == 11) return "R3";
      else if (r == 12) return "R1";
      else if (r == 13) return "R6/R4";
      else              return "R6";
   endfunction

   task automatic chk(input logic [NCH-1:0] exp, input string tag);
      n_vec++;
      if (busy !== exp) begin
         n_bad++;
         $display("FAIL %s: busy=%b expected %b", tag, busy, exp);
      end
   endtask

   // Called at a falling edge: drive, pass one rising edge, return at the next falling edge.
   task automatic step(input logic we, input logic [AW-1:0] a, input logic [CW-1:0] d);
      wr_en   = we;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(5'b00000, "R8 reset state");
      rst = 1'b0;

      for (int r = 0; r < ROWS; r++) begin
         step(VEC[r][22], VEC[r][21:19], VEC[r][18:5]);
         chk(VEC[r][4:0], row_tag(r));
      end

      // Let ch0 (4 left) run out.
      repeat (5) step(1'b0, '0, '0);
      chk(5'b00000, "R5 idle after run");

      // R7: out-of-range addresses stage nothing and launch nothing.
      step(1'b1, 3'd6, 14'd9);
      chk(5'b00000, "R7 addr 6");
      step(1'b1, 3'd7, 14'd1);
      chk(5'b00000, "R7 addr 7");
      step(1'b1, 3'd4, 14'd0);
      chk(5'b01011, "R7 no aliasing on launch");

      // R3: ch0 staged with 6 stays high for exactly six cycles.
      step(1'b0, '0, '0);
      chk(5'b01011, "R3 second cycle");
      for (int t = 0; t < 4; t++) begin
         step(1'b0, '0, '0);
         chk(5'b00001, "R3 ch0 tail");
      end
      step(1'b0, '0, '0);
      chk(5'b00000, "R3 ch0 expiry at 6");

      // R6: relaunch reuses held values.
      step(1'b1, 3'd4, 14'd3);
      chk(5'b11011, "R6 relaunch from held");

      // R8: reset mid-run clears counters and staged values.
      rst = 1'b1;
      step(1'b0, '0, '0);
      chk(5'b00000, "R8 reset mid-run");
      rst = 1'b0;
      step(1'b1, 3'd4, 14'd5);
      chk(5'b10000, "R8 staged values cleared");
      step(1'b0, '0, '0);
      chk(5'b10000, "R8 launch channel runs");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule